// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read-side controller of a bit-serial configuration store. It feeds an FPGA that loads itself in master serial mode. The FPGA supplies the clock, an active-low chip enable and a shared reset/output-enable level. The block answers with one configuration bit per clock, starting at address 0. When its last bit has gone out, it releases the data line and pulls its chain-enable output low. The next store in a daisy chain then takes over on the very next clock, with no idle cycle and no cycle where both drive.

The meaning of the shared reset/output-enable input is set by a polarity select. When the read-mode input is low, the block is in programming mode: reads are suspended and the read state is frozen. The tri-state data pin is modelled as a data bit plus a drive flag. The storage is a parameterised one-bit-wide array, preloaded through a plain write port. All outputs are registered, and a synchronous power-on reset clears the block.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: The write port stores `wr_data` at `wr_addr` on any clock with `wr_en` high. Reading starts at address 0 and steps by one address per qualifying rising edge. After the edge that selects address i, `dout_en` is 1 and `dout` equals the stored bit i.
- R2: The effective output-enable level is `rst_oe` XOR `pol_sel`. With `pol_sel`=0 (the default use), a low `rst_oe` is the reset level. With `pol_sel`=1, a high `rst_oe` is the reset level. While in read mode at the reset level, the next edge clears the address to 0 and sets `dout_en` to 0, whatever `ce_n` is.
- R3: With `ce_n` high, the address does not advance and `dout_en` is 0 after the edge. This holds whatever the output-enable level is.
- R4: With `por` high, the next edge clears the address and sets `dout_en` to 0 and `ce_out_n` to 1.
- R5: `ce_out_n` goes low on the same edge that delivers the last bit, at address DEPTH-1.
- R6: Once the last bit has been delivered, further enabled edges set `dout_en` to 0. No address is read again until the address is cleared.
- R7: After the last bit, `ce_out_n` copies `ce_n` with one edge of delay for as long as output enable stays active. Once the reset level is applied, `ce_out_n` stays 1 until the whole store has been read again.
- R8: With `read_mode` low, the address and chain state hold and `dout_en` is 0. This also applies at the reset level. Once `read_mode` returns high, reading resumes from the held address.
- R9: When two instances are chained through `ce_out_n` to `ce_n`, the FPGA sees the first store's bits followed directly by the second's. Exactly one instance drives on each of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock from the FPGA |
| por | input | 1 | Synchronous power-on reset, active high |
| read_mode | input | 1 | High: configuration read; low: programming mode |
| pol_sel | input | 1 | Polarity of `rst_oe` (0: low is reset) |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Shared reset / output-enable level |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Preload address |
| wr_data | input | 1 | Preload bit |
| dout | output | 1 | Serial configuration bit |
| dout_en | output | 1 | High when `dout` is driven onto the line |
| ce_out_n | output | 1 | Chain enable to the next store, active low |

## Verification
The assertions assume that `por` is held high from time zero until the first clock edges have passed. They also assume that every input changes away from the rising edge, so that each edge sees one stable level of `ce_n`, `rst_oe`, `pol_sel` and `read_mode`. The bench drives all inputs one time unit after a rising edge and starts with several cycles of `por`. The two chained instances share `rst_oe`, `pol_sel` and `read_mode`, as they would on a real board. The second instance's chip enable is driven only by the first instance's `ce_out_n`.

// File: rtl/cfg_reader_pkg.sv
package cfg_reader_pkg;

  // Chain-out control: armed until the last bit leaves, then spent.
  typedef enum logic {
    CO_ARMED = 1'b0,
    CO_SPENT = 1'b1
  } chain_state_e;

  // Effective output-enable level from the shared pin and its polarity.
  function automatic logic oe_level(input logic pin, input logic pol);
    return pin ^ pol;
  endfunction

endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data
);

  // One-bit-wide array with a registered read port (block RAM shape).
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last,
  output logic              spent
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      addr  <= '0;
      spent <= 1'b0;
    end else if (step) begin
      if (at_last) spent <= 1'b1;
      else         addr  <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_chain_out.sv
module cfg_chain_out
  import cfg_reader_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic hold,
  input  logic last_step,
  input  logic ce_n,
  output logic ce_out_n
);

  chain_state_e state;

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= CO_ARMED;
      ce_out_n <= 1'b1;
    end else if (!hold) begin
      if (last_step) begin
        state    <= CO_SPENT;
        ce_out_n <= 1'b0;
      end else if (state == CO_SPENT) begin
        ce_out_n <= ce_n;
      end else begin
        ce_out_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader
  import cfg_reader_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              por,
  input  logic              read_mode,
  input  logic              pol_sel,
  input  logic              ce_n,
  input  logic              rst_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  output logic              dout,
  output logic              dout_en,
  output logic              ce_out_n
);

  logic              oe_act;
  logic              clr;
  logic              step;
  logic              at_last;
  logic              spent;
  logic [ADDR_W-1:0] addr;

  assign oe_act = oe_level(rst_oe, pol_sel);
  assign clr    = por | (read_mode & ~oe_act);
  assign step   = read_mode & ~ce_n & oe_act & ~spent;

  cfg_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .clr     (clr),
    .step    (step),
    .addr    (addr),
    .at_last (at_last),
    .spent   (spent)
  );

  cfg_bit_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (step),
    .rd_addr (addr),
    .rd_data (dout)
  );

  cfg_chain_out u_chain (
    .clk       (clk),
    .clr       (clr),
    .hold      (~read_mode),
    .last_step (step & at_last),
    .ce_n      (ce_n),
    .ce_out_n  (ce_out_n)
  );

  always_ff @(posedge clk) begin
    if (por) dout_en <= 1'b0;
    else     dout_en <= step;
  end

endmodule

// File: rtl/cfg_bitstream_reader_chk.sv
module cfg_bitstream_reader_chk (
  input logic clk,
  input logic por,
  input logic read_mode,
  input logic pol_sel,
  input logic ce_n,
  input logic rst_oe,
  input logic dout_en,
  input logic ce_out_n
);

  logic oe_lvl;
  assign oe_lvl = rst_oe ^ pol_sel;

  p_float_on_reset_r2: assert property (@(posedge clk) disable iff (por)
    (read_mode && !oe_lvl) |=> !dout_en);

  p_standby_float_r3: assert property (@(posedge clk) disable iff (por)
    ce_n |=> !dout_en);

  p_handoff_float_r6: assert property (@(posedge clk) disable iff (por)
    (!ce_out_n && $past(!ce_out_n)) |-> !dout_en);

  p_ceo_high_on_reset_r7: assert property (@(posedge clk) disable iff (por)
    (read_mode && !oe_lvl) |=> ce_out_n);

  p_ceo_falls_with_ce_r7: assert property (@(posedge clk) disable iff (por)
    $fell(ce_out_n) |-> $past(!ce_n));

  p_progmode_float_r8: assert property (@(posedge clk) disable iff (por)
    !read_mode |=> !dout_en);

endmodule

bind cfg_bitstream_reader cfg_bitstream_reader_chk u_chk (
  .clk       (clk),
  .por       (por),
  .read_mode (read_mode),
  .pol_sel   (pol_sel),
  .ce_n      (ce_n),
  .rst_oe    (rst_oe),
  .dout_en   (dout_en),
  .ce_out_n  (ce_out_n)
);

// File: tb/cfg_bitstream_reader_tb.sv
module cfg_bitstream_reader_tb;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic por = 1'b1;
  logic read_mode = 1'b1;
  logic pol_sel = 1'b0;
  logic ce_n = 1'b1;
  logic rst_oe = 1'b0;
  logic wr_en0 = 1'b0, wr_en1 = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic wr_data = 1'b0;
  logic dout0, den0, ceo0, dout1, den1, ceo1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_bitstream_reader #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .por(por), .read_mode(read_mode), .pol_sel(pol_sel),
    .ce_n(ce_n), .rst_oe(rst_oe), .wr_en(wr_en0), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(dout0), .dout_en(den0), .ce_out_n(ceo0)
  );

  cfg_bitstream_reader #(.DEPTH(DEPTH)) u_dut2 (
    .clk(clk), .por(por), .read_mode(read_mode), .pol_sel(pol_sel),
    .ce_n(ceo0), .rst_oe(rst_oe), .wr_en(wr_en1), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(dout1), .dout_en(den1), .ce_out_n(ceo1)
  );

  // Stored bit for instance inst, pattern pass, address i.
  function automatic logic pat(int inst, int pass, int i);
    return ((i * 13 + inst * 5 + pass * 7) % 3) == 1;
  endfunction

  // Line seen by the FPGA: 0, 1, 2 = floating, 3 = both driving.
  function automatic int line_code();
    if (den0 && den1) return 3;
    if (den0) return int'(dout0);
    if (den1) return int'(dout1);
    return 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Drive the shared pin to an effective output-enable level.
  task automatic set_oe(logic want);
    rst_oe = want ^ pol_sel;
  endtask

  task automatic load(int pass);
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = ADDR_W'(i);
      wr_en0 = 1'b1; wr_en1 = 1'b0; wr_data = pat(0, pass, i);
      tick();
      wr_en0 = 1'b0; wr_en1 = 1'b1; wr_data = pat(1, pass, i);
      tick();
    end
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  task automatic chain_run(int pass);
    ce_n = 1'b0;
    set_oe(1'b0);
    tick();
    chk("R2 reset level floats", int'(den0), 0);
    set_oe(1'b1);
    for (int k = 0; k < 2 * DEPTH + 3; k++) begin
      int exp;
      tick();
      if (k < DEPTH)           exp = int'(pat(0, pass, k));
      else if (k < 2 * DEPTH)  exp = int'(pat(1, pass, k - DEPTH));
      else                     exp = 2;
      if (k < DEPTH) chk("R1 first store bit", line_code(), exp);
      else if (k < 2 * DEPTH) chk("R9 chained bit", line_code(), exp);
      else chk("R6 float after last bit", line_code(), exp);
      chk("R5 ce_out_n low from last bit", int'(ceo0), (k >= DEPTH - 1) ? 0 : 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    chk("R4 por dout_en", int'(den0), 0);
    chk("R4 por ce_out_n", int'(ceo0), 1);
    load(0);
    por = 1'b0;
    chain_run(0);

    // R7: follow ce_n after the end, then stay high once reset.
    ce_n = 1'b1; tick();
    chk("R7 ce_out_n follows ce_n high", int'(ceo0), 1);
    chk("R3 standby float", int'(den0), 0);
    ce_n = 1'b0; tick();
    chk("R7 ce_out_n follows ce_n low", int'(ceo0), 0);
    chk("R6 no re-read", line_code(), 2);
    set_oe(1'b0); tick();
    chk("R7 ce_out_n high on reset", int'(ceo0), 1);
    tick();
    chk("R7 ce_out_n stays high", int'(ceo0), 1);

    // R3: chip enable high with output enabled does not advance.
    ce_n = 1'b1; set_oe(1'b1);
    repeat (3) tick();
    chk("R3 ce_n high float", int'(den0), 0);
    chk("R3 ce_n high ce_out_n", int'(ceo0), 1);
    ce_n = 1'b0; tick();
    chk("R3 resumes at bit 0", line_code(), int'(pat(0, 0, 0)));
    tick();
    chk("R1 bit 1", line_code(), int'(pat(0, 0, 1)));

    // R8: programming mode holds state even at the reset level.
    read_mode = 1'b0; tick();
    chk("R8 prog mode float", int'(den0), 0);
    set_oe(1'b0); repeat (2) tick();
    chk("R8 prog mode float at reset level", int'(den0), 0);
    set_oe(1'b1); tick();
    read_mode = 1'b1; tick();
    chk("R8 resumes at bit 2", line_code(), int'(pat(0, 0, 2)));

    // R2: mid-stream reset clears the address.
    set_oe(1'b0); tick();
    chk("R2 reset mid-stream floats", int'(den0), 0);
    set_oe(1'b1); tick();
    chk("R2 restart at bit 0", line_code(), int'(pat(0, 0, 0)));

    // R2: inverted polarity, high level is reset.
    pol_sel = 1'b1; rst_oe = 1'b1; tick();
    chk("R2 inverted polarity reset", int'(den0), 0);
    rst_oe = 1'b0; tick();
    chk("R2 inverted polarity bit 0", line_code(), int'(pat(0, 0, 0)));
    tick();
    chk("R2 inverted polarity bit 1", line_code(), int'(pat(0, 0, 1)));

    // R4: power-on reset mid-stream.
    por = 1'b1; tick();
    chk("R4 por mid-stream dout_en", int'(den0), 0);
    chk("R4 por mid-stream ce_out_n", int'(ceo0), 1);
    por = 1'b0; tick();
    chk("R4 restart at bit 0", line_code(), int'(pat(0, 0, 0)));

    // Second full chained pass with a new pattern, inverted polarity.
    load(1);
    chain_run(1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule